// File: doc/BRIEF.md
# Exception Return Resolver

The block settles an exception return in one step. From the saved status word, the current exception level and the return address, it works out the level the return is aimed at. It checks that target against the configuration inputs: whether EL2 exists, the security state, the trap-general bit, the register width of each level, the top-byte-ignore enables, the address-range regime and the single-step state of each level. It then produces the status word and the program counter that execution resumes with.

A request strobe captures the inputs. One clock later the block raises `done_o` for a single cycle. With it come a legal flag, the new exception level, the new status word and the new program counter. These result registers keep their values until the next request.

A legal return enters the requested level and execution state. An illegal return stays at the current level and execution state. In that case it sets the illegal-state bit and takes only the condition flags and the interrupt masks from the saved word. Register banking and the stack pointer are handled outside this block.

Top module: `excret_resolver`

## Requirements
- R1: `done_o` is 1 exactly in the cycle after a clock edge that sampled `req_i` high, and 0 otherwise. Reset clears all outputs to zero.
- R2: When saved bit 4 is 1 the return targets the 32-bit state, and saved bits [4:0] decode as follows: 0x10 gives EL0; 0x1A gives EL2; 0x11, 0x12, 0x13, 0x17, 0x1B and 0x1F give EL1. Every other value, 0x16 included, is illegal.
- R3: When saved bit 4 is 0 the return targets the 64-bit state. It is illegal if saved bit 1 is set or if saved bits [3:0] equal 4'b0001. Otherwise the target level is saved bits [3:2].
- R4: The return is illegal if the target level is above `cur_el_i`, or if it is EL2 while `el2_impl_i` is 0.
- R5: For a nonzero target level n, the return is illegal if `el_is64_i[n]` is not equal to the inverse of saved bit 4.
- R6: The return is illegal if it targets EL2 while `secure_i` is 1, or EL1 while `tge_i` is 1.
- R7: On an illegal return the outputs are as follows:
  - `legal_o` is 0.
  - `new_el_o` equals `cur_el_i`.
  - `new_psw_o` is `cur_psw_i`, except that bits [31:28] and [9:6] are taken from the saved word and bit 20 is set.
  - `new_pc_o` equals `ret_addr_i`.
- R8: On a legal return `legal_o` is 1, `new_el_o` is the target level, and `new_psw_o` is the saved word with only bit 21 subject to R11.
- R9: On a legal 32-bit return `new_pc_o` is the low 32 bits of `ret_addr_i`, zero-extended. Bit 0 is cleared in every case. Bit 1 is cleared as well when saved bit 5 (Thumb) is 0.
- R10: On a legal 64-bit return the enable `tbi_en_i[ret_addr_i[55]]` decides the top byte. If that enable is 0, `ret_addr_i` passes unchanged. If it is 1, bits [63:56] become copies of bit 55 when `two_range_i` is 1, and become zero when `two_range_i` is 0.
- R11: Bit 21 (single-step) of `new_psw_o` is cleared unless `ss_act_i` is 1 for the resulting level. That level is the target on a legal return and `cur_el_i` on an illegal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| saved_psw_i | input | 32 | Saved status word |
| cur_el_i | input | 2 | Current exception level (1 to 3) |
| ret_addr_i | input | 64 | Return address |
| el2_impl_i | input | 1 | EL2 implemented |
| secure_i | input | 1 | Secure state |
| tge_i | input | 1 | Trap-general bit |
| el_is64_i | input | 4 | Per-level width map, 1 = 64-bit |
| tbi_en_i | input | 2 | Top-byte-ignore enables, indexed by address bit 55 |
| two_range_i | input | 1 | Two-range address regime |
| ss_act_i | input | 4 | Single-step active, one bit per level |
| cur_psw_i | input | 32 | Current status word |
| done_o | output | 1 | Result valid, one-cycle pulse |
| legal_o | output | 1 | Return legal |
| new_el_o | output | 2 | Resulting exception level |
| new_psw_o | output | 32 | Resulting status word |
| new_pc_o | output | 64 | Resulting program counter |

## Verification
The assertions take for granted that `cur_el_i` is never 0 while a request is presented. They also compare each result against the inputs of the cycle before, which assumes that every result follows from the single request sampled at that edge. The stimulus keeps the current level in 1 to 3 on every request, directed and random alike. Requests may come back to back, or be separated by idle gaps. The configuration is always changed on the same falling edge that presents a request, so each result belongs to exactly one set of inputs.

// File: rtl/excret_pkg.sv
package excret_pkg;
  localparam int PSW_W   = 32;
  localparam int NUM_EL  = 4;
  localparam int EL_W    = $clog2(NUM_EL);
  localparam int MODE_W  = 5;

  localparam int B_STATE = 4;
  localparam int B_THUMB = 5;
  localparam int DAIF_LO = 6;
  localparam int DAIF_HI = 9;
  localparam int B_ILL   = 20;
  localparam int B_STEP  = 21;
  localparam int FLAG_LO = 28;
  localparam int FLAG_HI = 31;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'h10,
    MODE_FIQ = 5'h11,
    MODE_IRQ = 5'h12,
    MODE_SVC = 5'h13,
    MODE_MON = 5'h16,
    MODE_ABT = 5'h17,
    MODE_HYP = 5'h1A,
    MODE_UND = 5'h1B,
    MODE_SYS = 5'h1F
  } mode32_e;

  typedef struct packed {
    logic            ok;
    logic            aa32;
    logic [EL_W-1:0] el;
  } target_t;

  function automatic logic [PSW_W-1:0] field_mask(input int lo, input int hi);
    logic [PSW_W-1:0] m;
    m = '0;
    for (int i = 0; i < PSW_W; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/excret_mode_dec.sv
module excret_mode_dec
  import excret_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output target_t           tgt_o
);
  always_comb begin
    tgt_o      = '0;
    tgt_o.aa32 = mode_i[B_STATE];
    if (mode_i[B_STATE]) begin
      case (mode_i)
        MODE_USR: begin tgt_o.ok = 1'b1; tgt_o.el = EL_W'(0); end
        MODE_HYP: begin tgt_o.ok = 1'b1; tgt_o.el = EL_W'(2); end
        MODE_FIQ, MODE_IRQ, MODE_SVC,
        MODE_ABT, MODE_UND, MODE_SYS: begin
          tgt_o.ok = 1'b1;
          tgt_o.el = EL_W'(1);
        end
        default: tgt_o.ok = 1'b0;  // monitor and reserved encodings
      endcase
    end else begin
      tgt_o.ok = !mode_i[1] && (mode_i[3:0] != 4'b0001);
      tgt_o.el = mode_i[3:2];
    end
  end
endmodule

// File: rtl/excret_rules.sv
module excret_rules
  import excret_pkg::*;
(
  input  target_t           tgt_i,
  input  logic [EL_W-1:0]   cur_el_i,
  input  logic              el2_impl_i,
  input  logic              secure_i,
  input  logic              tge_i,
  input  logic [NUM_EL-1:0] el_is64_i,
  output logic              legal_o
);
  logic too_high, no_el2, width_bad, sec_el2, tge_el1;

  always_comb begin
    too_high  = tgt_i.el > cur_el_i;
    no_el2    = (tgt_i.el == EL_W'(2)) && !el2_impl_i;
    width_bad = (tgt_i.el != '0) && (el_is64_i[tgt_i.el] == tgt_i.aa32);
    sec_el2   = (tgt_i.el == EL_W'(2)) && secure_i;
    tge_el1   = (tgt_i.el == EL_W'(1)) && tge_i;
    legal_o   = tgt_i.ok && !(too_high || no_el2 || width_bad || sec_el2 || tge_el1);
  end
endmodule

// File: rtl/excret_pc_fix.sv
module excret_pc_fix #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              legal_i,
  input  logic              aa32_i,
  input  logic              thumb_i,
  input  logic [1:0]        tbi_en_i,
  input  logic              two_range_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam int TAG_W    = 8;
  localparam int TAG_LSB  = ADDR_W - TAG_W;
  localparam int SEL_BIT  = TAG_LSB - 1;
  localparam int NARROW_W = 32;

  logic [NARROW_W-1:0] narrow;
  logic                tag_on;

  always_comb begin
    narrow    = addr_i[NARROW_W-1:0];
    narrow[0] = 1'b0;
    if (!thumb_i) narrow[1] = 1'b0;
    tag_on = tbi_en_i[addr_i[SEL_BIT]];
    pc_o   = addr_i;
    if (legal_i) begin
      if (aa32_i) begin
        pc_o = {{(ADDR_W-NARROW_W){1'b0}}, narrow};
      end else if (tag_on) begin
        pc_o[ADDR_W-1:TAG_LSB] = two_range_i ? {TAG_W{addr_i[SEL_BIT]}} : '0;
      end
    end
  end
endmodule

// File: rtl/excret_psw_mux.sv
module excret_psw_mux
  import excret_pkg::*;
(
  input  logic [PSW_W-1:0]  saved_i,
  input  logic [PSW_W-1:0]  cur_i,
  input  logic              legal_i,
  input  logic [EL_W-1:0]   tgt_el_i,
  input  logic [EL_W-1:0]   cur_el_i,
  input  logic [NUM_EL-1:0] ss_act_i,
  output logic [PSW_W-1:0]  psw_o,
  output logic [EL_W-1:0]   el_o
);
  localparam logic [PSW_W-1:0] TAKE_MASK =
    field_mask(FLAG_LO, FLAG_HI) | field_mask(DAIF_LO, DAIF_HI);

  always_comb begin
    if (legal_i) begin
      psw_o = saved_i;
      el_o  = tgt_el_i;
    end else begin
      psw_o        = (cur_i & ~TAKE_MASK) | (saved_i & TAKE_MASK);
      psw_o[B_ILL] = 1'b1;
      el_o         = cur_el_i;
    end
    if (!ss_act_i[el_o]) psw_o[B_STEP] = 1'b0;
  end
endmodule

// File: rtl/excret_resolver.sv
module excret_resolver
  import excret_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [PSW_W-1:0]  saved_psw_i,
  input  logic [EL_W-1:0]   cur_el_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  input  logic              el2_impl_i,
  input  logic              secure_i,
  input  logic              tge_i,
  input  logic [NUM_EL-1:0] el_is64_i,
  input  logic [1:0]        tbi_en_i,
  input  logic              two_range_i,
  input  logic [NUM_EL-1:0] ss_act_i,
  input  logic [PSW_W-1:0]  cur_psw_i,
  output logic              done_o,
  output logic              legal_o,
  output logic [EL_W-1:0]   new_el_o,
  output logic [PSW_W-1:0]  new_psw_o,
  output logic [ADDR_W-1:0] new_pc_o
);
  target_t           tgt;
  logic              legal_d;
  logic [PSW_W-1:0]  psw_d;
  logic [EL_W-1:0]   el_d;
  logic [ADDR_W-1:0] pc_d;

  excret_mode_dec u_dec (
    .mode_i (saved_psw_i[MODE_W-1:0]),
    .tgt_o  (tgt)
  );

  excret_rules u_rules (
    .tgt_i      (tgt),
    .cur_el_i   (cur_el_i),
    .el2_impl_i (el2_impl_i),
    .secure_i   (secure_i),
    .tge_i      (tge_i),
    .el_is64_i  (el_is64_i),
    .legal_o    (legal_d)
  );

  excret_psw_mux u_psw (
    .saved_i  (saved_psw_i),
    .cur_i    (cur_psw_i),
    .legal_i  (legal_d),
    .tgt_el_i (tgt.el),
    .cur_el_i (cur_el_i),
    .ss_act_i (ss_act_i),
    .psw_o    (psw_d),
    .el_o     (el_d)
  );

  excret_pc_fix #(.ADDR_W(ADDR_W)) u_pc (
    .addr_i      (ret_addr_i),
    .legal_i     (legal_d),
    .aa32_i      (tgt.aa32),
    .thumb_i     (saved_psw_i[B_THUMB]),
    .tbi_en_i    (tbi_en_i),
    .two_range_i (two_range_i),
    .pc_o        (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      legal_o   <= 1'b0;
      new_el_o  <= '0;
      new_psw_o <= '0;
      new_pc_o  <= '0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        legal_o   <= legal_d;
        new_el_o  <= el_d;
        new_psw_o <= psw_d;
        new_pc_o  <= pc_d;
      end
    end
  end
endmodule

// File: rtl/excret_resolver_chk.sv
module excret_resolver_chk
  import excret_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [PSW_W-1:0]  saved_psw_i,
  input logic [EL_W-1:0]   cur_el_i,
  input logic              el2_impl_i,
  input logic              tge_i,
  input logic              done_o,
  input logic              legal_o,
  input logic [EL_W-1:0]   new_el_o,
  input logic [PSW_W-1:0]  new_psw_o,
  input logic [ADDR_W-1:0] new_pc_o
);
  assert_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
  assert_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o);
  assert_no_raise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && legal_o) |-> (new_el_o <= $past(cur_el_i)));
  assert_el2_absent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && legal_o && !$past(el2_impl_i)) |-> (new_el_o != EL_W'(2)));
  assert_tge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && legal_o && $past(tge_i)) |-> (new_el_o != EL_W'(1)));
  assert_ill_stay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !legal_o) |-> (new_el_o == $past(cur_el_i) && new_psw_o[B_ILL]));
  assert_ill_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !legal_o) |->
      (new_psw_o[FLAG_HI:FLAG_LO] == $past(saved_psw_i[FLAG_HI:FLAG_LO]) &&
       new_psw_o[DAIF_HI:DAIF_LO] == $past(saved_psw_i[DAIF_HI:DAIF_LO])));
  assert_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && legal_o && new_psw_o[B_STATE]) |->
      (!new_pc_o[0] && new_pc_o[ADDR_W-1:32] == '0));
endmodule

bind excret_resolver excret_resolver_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .saved_psw_i (saved_psw_i),
  .cur_el_i    (cur_el_i),
  .el2_impl_i  (el2_impl_i),
  .tge_i       (tge_i),
  .done_o      (done_o),
  .legal_o     (legal_o),
  .new_el_o    (new_el_o),
  .new_psw_o   (new_psw_o),
  .new_pc_o    (new_pc_o)
);

// File: tb/excret_resolver_tb_top.sv
`timescale 1ns/1ps
module excret_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] saved = '0;
  logic [1:0]  cur_el = 2'd1;
  logic [63:0] ra = '0;
  logic        el2 = 1'b1, sec = 1'b0, tge = 1'b0, tr = 1'b0;
  logic [3:0]  w64 = 4'b1111, ss = 4'b0000;
  logic [1:0]  tbi = 2'b00;
  logic [31:0] cpsw = '0;

  logic        done, legal;
  logic [1:0]  nel;
  logic [31:0] npsw;
  logic [63:0] npc;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  excret_resolver dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .saved_psw_i(saved),
    .cur_el_i(cur_el), .ret_addr_i(ra), .el2_impl_i(el2), .secure_i(sec),
    .tge_i(tge), .el_is64_i(w64), .tbi_en_i(tbi), .two_range_i(tr),
    .ss_act_i(ss), .cur_psw_i(cpsw), .done_o(done), .legal_o(legal),
    .new_el_o(nel), .new_psw_o(npsw), .new_pc_o(npc));

  typedef struct packed {
    bit        legal;
    bit [1:0]  el;
    bit [31:0] psw;
    bit [63:0] pc;
  } exp_t;

  function automatic exp_t predict();
    exp_t e;
    int   t = 0;
    bit   ok = 1;
    bit   a32 = saved[4];
    int   rel;
    if (a32) begin
      case (saved[4:0])
        5'h10: t = 0;
        5'h1A: t = 2;
        5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F: t = 1;
        default: ok = 0;
      endcase
    end else if (saved[1] || saved[3:0] == 4'b0001) ok = 0;
    else t = int'(saved[3:2]);
    if (ok) begin
      if (t > int'(cur_el)) ok = 0;
      if (t == 2 && !el2) ok = 0;
      if (t != 0 && w64[t] == a32) ok = 0;
      if (t == 2 && sec) ok = 0;
      if (t == 1 && tge) ok = 0;
    end
    e.legal = ok;
    if (ok) begin
      e.psw = saved; rel = t; e.el = 2'(t);
      if (a32) begin
        e.pc = {32'h0, ra[31:0]};
        e.pc[0] = 0;
        if (!saved[5]) e.pc[1] = 0;
      end else begin
        e.pc = ra;
        if (tbi[ra[55]]) e.pc[63:56] = tr ? {8{ra[55]}} : 8'h00;
      end
    end else begin
      e.psw = cpsw;
      e.psw[31:28] = saved[31:28];
      e.psw[9:6] = saved[9:6];
      e.psw[20] = 1;
      rel = int'(cur_el); e.el = cur_el;
      e.pc = ra;
    end
    if (!ss[rel]) e.psw[21] = 0;
    return e;
  endfunction

  exp_t  exp_q;
  bit    exp_v = 0;
  string tag = "R1", exp_tag = "R1";

  always @(posedge clk) begin
    if (rst_n) begin
      exp_v <= req;
      if (req) begin
        exp_q   <= predict();
        exp_tag <= tag;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_chk++;
      if (done !== exp_v) begin
        n_bad++;
        $display("FAIL R1 done actual=%0b expected=%0b", done, exp_v);
      end
      if (exp_v) begin
        n_chk++;
        if ({legal, nel, npsw, npc} !== {exp_q.legal, exp_q.el, exp_q.psw, exp_q.pc}) begin
          n_bad++;
          $display("FAIL %s actual legal=%0b el=%0d psw=%h pc=%h expected legal=%0b el=%0d psw=%h pc=%h",
                   exp_tag, legal, nel, npsw, npc,
                   exp_q.legal, exp_q.el, exp_q.psw, exp_q.pc);
        end
      end
    end
  end

  task automatic send(input string t, input [31:0] s, input [1:0] ce,
                      input [63:0] a, input bit hold = 0);
    tag = t; saved = s; cur_el = ce; ra = a; req = 1'b1;
    @(negedge clk);
    if (!hold) req = 1'b0;
  endtask

  task automatic idle(input int n);
    req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if ({done, legal, nel, npsw, npc} !== '0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%h expected=0", {done, legal, nel, npsw, npc});
    end
    rst_n = 1'b1;
    @(negedge clk);
    cpsw = 32'h0F0F_F0F5;

    // R2 32-bit mode decode
    w64 = 4'b1000;
    send("R2", 32'hA000_01D0, 2'd1, 64'hFFFF_0000_ABCD_1237);
    send("R2", 32'h0000_001A, 2'd3, 64'h1000);
    send("R2", 32'h0000_0016, 2'd3, 64'h1000);
    send("R2", 32'h0000_0014, 2'd3, 64'h1000);
    send("R2", 32'h5000_0013, 2'd1, 64'h2222);
    send("R2", 32'h0000_001F, 2'd2, 64'h2226);
    // R3 64-bit field rules
    w64 = 4'b1111;
    send("R3", 32'h0000_0005, 2'd2, 64'h4000);
    send("R3", 32'h0000_0001, 2'd2, 64'h4000);
    send("R3", 32'h0000_0002, 2'd2, 64'h4000);
    send("R3", 32'h9000_0000, 2'd1, 64'h4004);
    // R4 target level limits
    send("R4", 32'h0000_0009, 2'd1, 64'h8000);
    el2 = 0;
    send("R4", 32'h0000_0009, 2'd3, 64'h8000);
    el2 = 1;
    send("R4", 32'h0000_000D, 2'd3, 64'h8008);
    // R5 width mismatch
    w64 = 4'b1101;
    send("R5", 32'h0000_0005, 2'd2, 64'h10);
    w64 = 4'b1111;
    send("R5", 32'h0000_0013, 2'd2, 64'h10);
    // R6 secure / trap-general
    sec = 1;
    send("R6", 32'h0000_0009, 2'd3, 64'h20);
    sec = 0; tge = 1;
    send("R6", 32'h0000_0005, 2'd2, 64'h20);
    send("R6", 32'h0000_0000, 2'd2, 64'h24);
    tge = 0;
    // R7 illegal keeps current fields
    cpsw = 32'h6A5A_5A5A;
    send("R7", 32'hF000_03C2, 2'd2, 64'hDEAD_BEEF_0000_0003);
    // R8 legal saved word pass-through
    send("R8", 32'hC0F0_0345, 2'd3, 64'h0000_0000_0000_1000);
    // R9 32-bit PC alignment
    w64 = 4'b0000;
    send("R9", 32'h0000_0030, 2'd1, 64'h1234_5678_9ABC_DEF3);
    send("R9", 32'h0000_0010, 2'd1, 64'h1234_5678_9ABC_DEF3);
    w64 = 4'b1111;
    // R10 top-byte handling
    tbi = 2'b10; tr = 1;
    send("R10", 32'h0000_0004, 2'd1, 64'h1280_0000_0000_1000);
    tr = 0;
    send("R10", 32'h0000_0004, 2'd1, 64'h1280_0000_0000_1000);
    tbi = 2'b01;
    send("R10", 32'h0000_0004, 2'd1, 64'h1280_0000_0000_1000);
    tr = 1;
    send("R10", 32'h0000_0004, 2'd1, 64'hFF00_0000_0000_1000);
    // R11 single-step
    ss = 4'b0010;
    send("R11", 32'h0020_0004, 2'd2, 64'h40);
    send("R11", 32'h0020_0008, 2'd2, 64'h40);
    ss = 4'b0100;
    send("R11", 32'h0020_0001, 2'd2, 64'h40);
    send("R11", 32'h0020_0004, 2'd3, 64'h40);
    // R1 back-to-back then gap
    send("R1", 32'h0000_0004, 2'd1, 64'h50, 1);
    send("R1", 32'h0000_0001, 2'd1, 64'h54, 1);
    send("R1", 32'h0000_0000, 2'd3, 64'h58);
    idle(2);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] s;
      s = $urandom;
      if ($urandom_range(0, 1) == 1) s[4:0] = 5'($urandom_range(0, 15));
      el2  = 1'($urandom);
      sec  = 1'($urandom);
      tge  = 1'($urandom);
      w64  = 4'($urandom);
      tbi  = 2'($urandom);
      tr   = 1'($urandom);
      ss   = 4'($urandom);
      cpsw = $urandom;
      send("RND", s, 2'($urandom_range(1, 3)), {$urandom, $urandom},
           $urandom_range(0, 2) == 0);
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(2);
    summary();
  end
endmodule